// File: doc/BRIEF.md
# Transfer Activation Source Arbiter

This block sits between the peripheral request lines of a chip and two consumers: the interrupt controller and a data-transfer engine. A bank of software-writable enable bits, eight to a register, decides for each request line whether it goes to the interrupt controller as an ordinary interrupt or to the transfer engine as an activation. Enabled requests are captured in a pending latch. One of them is picked by fixed priority, with the lowest source index winning, and its index is offered to the engine through a valid/ready handshake.

When the engine reports that the transfer has finished, the arbiter clears the source in one of two ways. If the engine marks the transfer as final, the source's enable bit is cleared, so the next request from that source reaches the interrupt controller. Otherwise, if the source is of a flag-clearing type, the arbiter pulses a clear strobe back to the peripheral. Activation takes no account of any CPU interrupt mask, and no such input exists. Requests that arrive while a transfer is in progress stay pending and are arbitrated by the same priority once the engine is free.

Top module: `xact_arbiter`

## Requirements
- R1: Enable bits come out of reset as 0 and are reached through NUM_SRC/8 eight-bit registers. Source i is bit i%8 of register i/8. A write with `en_wr` high stores `en_wdata` into register `en_addr` at the clock edge. `en_rdata` shows register `en_addr` combinationally.
- R2: `irq_out[i]` equals `irq_req[i]` in the same cycle when the enable bit of source i is 0, and is 0 whenever that enable bit is 1. A source that is not enabled never produces an activation.
- R3: A request on an enabled source, even a single-cycle pulse, is held pending until that source is granted.
- R4: When the block leaves the idle state, `act_idx` names the lowest-index pending source. `act_valid` rises two clock edges after an enabled request is sampled. While `act_valid` is high and `act_ready` is low, `act_idx` stays unchanged, even if a source with a lower index becomes pending.
- R5: Requests that become pending while a transfer is in progress (after the edge where `act_ready` is accepted and before the edge where `done_valid` is taken) are offered after completion, in ascending index order.
- R6: When `done_valid` and `done_final` are both high, the enable bit of the serviced source reads 0 after that edge. A later request from that source then appears on `irq_out`.
- R7: When `done_valid` is high with `done_final` low, `flag_clr` carries a one-cycle one-hot pulse on the serviced source's bit in the cycle after that edge. This happens only if that bit of FLAGCLR_MASK is 1 (default 16'h00F0, sources 4 to 7). Otherwise `flag_clr` stays 0. In both cases the enable bit is unchanged.
- R8: If a software write to a register lands on the same edge as a hardware clear of one of its bits, that bit becomes 0 and the other bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_SRC | Peripheral request lines |
| irq_out | output | NUM_SRC | Requests routed to the interrupt controller |
| en_wr | input | 1 | Enable register write strobe |
| en_addr | input | AW | Enable register select for read and write |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read data |
| act_valid | output | 1 | Activation offered to the engine |
| act_idx | output | IW | Index of the offered source |
| act_ready | input | 1 | Engine accepts the offered activation |
| done_valid | input | 1 | Engine reports the transfer finished |
| done_final | input | 1 | The finished transfer was the final one |
| flag_clr | output | NUM_SRC | One-cycle strobe clearing a peripheral status flag |

## Verification
The assertions assume that the engine obeys the handshake. `act_ready` is only raised while `act_valid` is high. `done_valid` comes only after an accepted activation, once per accepted activation, and lasts a single cycle. Under those assumptions, the properties on index stability, the flag-clear pulse and the enable clear hold. The stimulus respects this by driving the engine side only from one serve sequence and from a few inline sequences that wait for `act_valid` before accepting. Each sequence raises `done_valid` for exactly one cycle while a transfer is in progress.

// File: rtl/xact_pkg.sv
// Package: shared types for the transfer activation arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package xact_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_BUSY  = 2'd2
    } xact_state_e;
endpackage

// File: rtl/xact_enable_regs.sv
// Module: xact_enable_regs
// Holds the per-source enable bits as eight-bit registers. Applies software
// writes, and gives hardware clears priority over a write on the same edge.
// Assumes NUM_SRC is a multiple of 8 and hw_clr is at most one-hot.
module xact_enable_regs #(
    parameter int NUM_SRC = 16,
    parameter int AW      = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [7:0]         wr_data,
    input  logic [NUM_SRC-1:0] hw_clr,
    output logic [7:0]         rd_data,
    output logic [NUM_SRC-1:0] en
);
    localparam int NREG = NUM_SRC / 8;

    for (genvar r = 0; r < NREG; r++) begin : g_bank
        logic [7:0] q;
        logic [7:0] nxt;

        // Select the written value or the held value for this register.
        always_comb begin
            nxt = q;
            if (wr_en && addr == AW'(r)) nxt = wr_data;
        end

        // Store the register, masking out any bit under hardware clear (R8).
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= nxt & ~hw_clr[r*8 +: 8];
        end

        assign en[r*8 +: 8] = q;
    end

    // Read multiplexer over the register bank (R1).
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NREG; r++)
            if (addr == AW'(r)) rd_data = en[r*8 +: 8];
    end

    // A hardware-cleared bit reads 0 after the edge (R6, R8).
    assert_hw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr != '0) |=> ((en & $past(hw_clr)) == '0));
endmodule

// File: rtl/xact_pending.sv
// Module: xact_pending
// Latches enabled requests until the source is granted, so single-cycle
// pulses are kept. A new request in the grant cycle re-arms the bit.
// Assumes grant_oh is at most one-hot.
module xact_pending #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] grant_oh,
    output logic [NUM_SRC-1:0] pend
);
    // Set on enabled request, clear on grant; setting wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~grant_oh) | (req & en);
    end

    // An enabled request is pending after the next edge (R3).
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((req & en) != '0) |=> ((pend & $past(req & en)) == $past(req & en)));

    // Only a pending source can be granted (R3).
    assert_grant_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_oh & ~pend) == '0);
endmodule

// File: rtl/xact_prio_pick.sv
// Module: xact_prio_pick
// Fixed-priority picker: reports whether any bit is set, and the index of
// the lowest set bit. Purely combinational.
module xact_prio_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top down so that the lowest set index is kept.
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (vec[i]) idx = IW'(i);
    end
endmodule

// File: rtl/xact_arbiter.sv
// Module: xact_arbiter (top)
// Routes each peripheral request to the interrupt controller or to the
// transfer engine according to its enable bit. Arbitrates pending
// activations by lowest index, runs the valid/ready offer, and performs
// clear-control when the engine reports completion.
// Assumes: act_ready only while act_valid; one single-cycle done_valid
// per accepted activation, arriving while busy.
module xact_arbiter
    import xact_pkg::*;
#(
    parameter int                 NUM_SRC      = 16,
    parameter logic [NUM_SRC-1:0] FLAGCLR_MASK = 16'h00F0,
    parameter int                 IW           = $clog2(NUM_SRC),
    parameter int                 AW           = (NUM_SRC / 8 > 1) ? $clog2(NUM_SRC / 8) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    output logic [NUM_SRC-1:0] irq_out,
    input  logic               en_wr,
    input  logic [AW-1:0]      en_addr,
    input  logic [7:0]         en_wdata,
    output logic [7:0]         en_rdata,
    output logic               act_valid,
    output logic [IW-1:0]      act_idx,
    input  logic               act_ready,
    input  logic               done_valid,
    input  logic               done_final,
    output logic [NUM_SRC-1:0] flag_clr
);
    xact_state_e        state;
    logic [IW-1:0]      cur_idx;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant_oh;
    logic [NUM_SRC-1:0] hw_clr;
    logic [NUM_SRC-1:0] cur_oh;
    logic               pick_any;
    logic [IW-1:0]      pick_idx;

    function automatic logic [NUM_SRC-1:0] low_mask(input logic [IW-1:0] i);
        return (NUM_SRC'(1) << i) - NUM_SRC'(1);
    endfunction

    xact_enable_regs #(.NUM_SRC(NUM_SRC), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(en_wr), .addr(en_addr),
        .wr_data(en_wdata), .hw_clr(hw_clr), .rd_data(en_rdata), .en(en)
    );

    xact_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .en(en),
        .grant_oh(grant_oh), .pend(pend)
    );

    xact_prio_pick #(.N(NUM_SRC), .IW(IW)) u_pick (
        .vec(pend), .any(pick_any), .idx(pick_idx)
    );

    // Route requests of disabled sources to the interrupt controller (R2).
    assign irq_out = irq_req & ~en;

    // Decode the grant and the enable clear from the handshake.
    always_comb begin
        cur_oh   = NUM_SRC'(1) << cur_idx;
        grant_oh = (state == ST_OFFER && act_ready) ? cur_oh : '0;
        hw_clr   = (state == ST_BUSY && done_valid && done_final) ? cur_oh : '0;
    end

    assign act_valid = (state == ST_OFFER);
    assign act_idx   = cur_idx;

    // Offer/transfer sequencing and the registered flag-clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_idx  <= '0;
            flag_clr <= '0;
        end else begin
            flag_clr <= (state == ST_BUSY && done_valid && !done_final)
                        ? (cur_oh & FLAGCLR_MASK) : '0;
            case (state)
                ST_IDLE:  if (pick_any) begin
                              cur_idx <= pick_idx;
                              state   <= ST_OFFER;
                          end
                ST_OFFER: if (act_ready)  state <= ST_BUSY;
                ST_BUSY:  if (done_valid) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // The offered index holds until accepted (R4).
    assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && !act_ready) |=> (act_valid && act_idx == $past(act_idx)));

    // The chosen source was pending and no lower index was pending (R4).
    assert_pick_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pend != '0) |=>
        ((($past(pend) >> act_idx) & NUM_SRC'(1)) == NUM_SRC'(1)) &&
        (($past(pend) & low_mask(act_idx)) == '0));

    // Flag clear is at most one-hot and lasts a single cycle (R7).
    assert_flag_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr));
    assert_flag_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr != '0) |=> (flag_clr == '0));

    // Flag clear only follows a non-final completion (R7).
    assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr != '0) |-> $past(done_valid && !done_final));
endmodule

// File: tb/xact_arbiter_test.sv
module xact_arbiter_test;
    localparam int          NS   = 16;
    localparam logic [15:0] FMSK = 16'h00F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic [15:0] irq_out;
    logic        en_wr = 1'b0;
    logic [0:0]  en_addr = '0;
    logic [7:0]  en_wdata = '0;
    logic [7:0]  en_rdata;
    logic        act_valid;
    logic [3:0]  act_idx;
    logic        act_ready = 1'b0;
    logic        done_valid = 1'b0;
    logic        done_final = 1'b0;
    logic [15:0] flag_clr;

    int checks = 0;
    int fails  = 0;

    localparam logic [15:0] VEC [0:5] = '{16'h0001, 16'h8000, 16'h8001,
                                          16'h0F00, 16'h1234, 16'hF0F0};

    always #4 clk = ~clk;

    xact_arbiter #(.NUM_SRC(NS), .FLAGCLR_MASK(FMSK)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_out(irq_out),
        .en_wr(en_wr), .en_addr(en_addr), .en_wdata(en_wdata), .en_rdata(en_rdata),
        .act_valid(act_valid), .act_idx(act_idx), .act_ready(act_ready),
        .done_valid(done_valid), .done_final(done_final), .flag_clr(flag_clr)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [7:0] d);
        en_wr = 1'b1; en_addr = 1'(a); en_wdata = d;
        tick();
        en_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input int a, input logic [7:0] exp);
        en_addr = 1'(a);
        #1;
        check(tag, en_rdata, exp);
    endtask

    task automatic pulse(input logic [15:0] p);
        irq_req = p;
        tick();
        irq_req = '0;
    endtask

    task automatic wait_valid();
        for (int n = 0; n < 20 && !act_valid; n++) tick();
    endtask

    // Accept one activation, complete it, and check the clear strobe.
    task automatic serve(input int exp_idx, input bit fin, input logic [15:0] exp_flag);
        wait_valid();
        check("R4 valid", act_valid, 1);
        check("R4 idx", act_idx, exp_idx);
        act_ready = 1'b1;
        tick();
        act_ready = 1'b0;
        done_valid = 1'b1; done_final = fin;
        tick();
        done_valid = 1'b0; done_final = 1'b0;
        check("R7 flag_clr", flag_clr, exp_flag);
        tick();
        check("R7 flag_clr end", flag_clr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // Reset state (R1)
        check("R1 reset act_valid", act_valid, 0);
        check("R1 reset flag_clr", flag_clr, 0);
        rd_check("R1 reset reg0", 0, 8'h00);
        rd_check("R1 reset reg1", 1, 8'h00);
        check("R2 reset irq_out", irq_out, 0);
        // R1: write and read back
        wr_reg(1, 8'hA5);
        rd_check("R1 readback reg1", 1, 8'hA5);
        wr_reg(1, 8'h00);
        wr_reg(0, 8'h0F);
        rd_check("R1 readback reg0", 0, 8'h0F);

        // R2: source 5 disabled routes to irq_out, source 2 enabled does not
        irq_req = 16'h0024;
        #1;
        check("R2 routing", irq_out, 16'h0020);
        tick();
        irq_req = '0;
        serve(2, 1'b0, 16'h0000);
        tick(); tick();
        check("R2 disabled no activation", act_valid, 0);

        // R6: final transfer clears enable; next request becomes an interrupt
        wr_reg(0, 8'hFF);
        pulse(16'h0010);
        serve(4, 1'b1, 16'h0000);
        rd_check("R6 enable cleared", 0, 8'hEF);
        irq_req = 16'h0010;
        #1;
        check("R6 irq after clear", irq_out, 16'h0010);
        tick();
        irq_req = '0;
        tick(); tick();
        check("R6 no activation", act_valid, 0);

        // R7: non-final on flag-clearing source 5 pulses flag_clr, enable kept
        pulse(16'h0020);
        serve(5, 1'b0, 16'h0020);
        rd_check("R7 enable kept", 0, 8'hEF);

        // R5 / R3: pulses during a transfer are serviced afterwards in order
        wr_reg(1, 8'hFF);
        pulse(16'h0200);
        wait_valid();
        check("R5 first idx", act_idx, 9);
        act_ready = 1'b1;
        tick();
        act_ready = 1'b0;
        pulse(16'h1000);
        pulse(16'h0040);
        done_valid = 1'b1;
        tick();
        done_valid = 1'b0;
        check("R7 no flag for 9", flag_clr, 0);
        serve(6, 1'b0, 16'h0040);
        serve(12, 1'b0, 16'h0000);

        // R4: offered index holds while a lower index arrives
        pulse(16'h0400);
        wait_valid();
        pulse(16'h0002);
        tick(); tick();
        check("R4 hold valid", act_valid, 1);
        check("R4 hold idx", act_idx, 10);
        serve(10, 1'b0, 16'h0000);
        serve(1, 1'b0, 16'h0000);

        // R8: hardware clear beats a same-edge software write
        pulse(16'h0100);
        wait_valid();
        check("R8 idx", act_idx, 8);
        act_ready = 1'b1;
        tick();
        act_ready = 1'b0;
        done_valid = 1'b1; done_final = 1'b1;
        en_wr = 1'b1; en_addr = 1'b1; en_wdata = 8'hFF;
        tick();
        done_valid = 1'b0; done_final = 1'b0; en_wr = 1'b0;
        rd_check("R8 collision", 1, 8'hFE);
        check("R8 no flag", flag_clr, 0);

        // Vector walk: priority order over several request patterns (R4, R5, R7)
        wr_reg(0, 8'hFF);
        wr_reg(1, 8'hFF);
        foreach (VEC[v]) begin
            logic [15:0] rem;
            rem = VEC[v];
            pulse(VEC[v]);
            while (rem != '0) begin
                int e;
                e = 0;
                for (int b = 15; b >= 0; b--) if (rem[b]) e = b;
                serve(e, 1'b0, FMSK & (16'h1 << e));
                rem[e] = 1'b0;
            end
            tick(); tick();
            check("R4 drained", act_valid, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule